// File: doc/BRIEF.md
# SPI Slave Bridge with Host Direction Line and Byte-Ready Flag

This block lets a controller chip talk to a host that can only be an SPI master, while still letting the controller start traffic toward the host. Two extra wires carry the flow control. The host drives a direction line, `host_read`. While it is high for a byte, the byte on MOSI is a command and is kept. While it is low, the MOSI byte is filler and the slave sends back one byte of its own on MISO. The slave drives `byte_rdy` high whenever it has an outbound byte waiting. The host polls that line and clocks out filler bytes to collect data.

A local processor on the system clock sees two valid/ready streams. It pushes outbound bytes through `ob_*` and pops received command bytes from `ib_*`. A push completes on a clock where `ob_valid` and `ob_ready` are both high. `ob_ready` is low while the outbound queue is full, and the offered byte must then be held. A pop completes on a clock where `ib_valid` and `ib_ready` are both high. `ib_data` stays unchanged while `ib_valid` is high and `ib_ready` is low. Both queues keep their bytes in order.

The SPI pins and the direction line pass through two-flop synchronisers into the system clock. All framing happens in that domain. This needs a system clock at least eight times faster than SCLK.

Top module: `spi_sideband_bridge`

## Requirements
- R1: After reset, `byte_rdy`, `ib_valid`, `underflow`, `overflow` and `spi_miso` are 0 and `ob_ready` is 1.
- R2: `byte_rdy` is high exactly when the outbound queue holds at least one byte. It follows a push or a pop within two system clocks.
- R3: The link uses SPI mode 0, with MSB first, MOSI sampled on SCLK rising edges and MISO changed after falling edges. A byte received with `host_read` = 1 is pushed into the inbound queue.
- R4: A byte with `host_read` = 0 puts nothing into the inbound queue. The head of the outbound queue appears on MISO MSB first, and that byte is removed from the queue at the first rising edge of the byte.
- R5: `host_read` is sampled only at the first SCLK rising edge of each byte. Changing it later in the same byte has no effect on that byte.
- R6: One chip-select low period can carry a burst of 40 or more bytes in any mix of directions. A new byte begins every 8 rising edges.
- R7: A filler byte that arrives while the outbound queue is empty sends 0x00 on MISO and sets `underflow`. `underflow` stays set until reset.
- R8: A command byte that completes while the inbound queue is full is dropped and sets `overflow`. `overflow` stays set until reset. The bytes already queued are unchanged.
- R9: Raising `spi_cs_n` (active low) clears the bit count. A partial byte is discarded, and the next byte is framed from the first rising edge after chip select falls again.
- R10: While the outbound queue is full, `ob_ready` is 0 and an offered byte is not taken. The streams keep order, and `ib_data` is held while it waits to be popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data to the host |
| host_read | input | 1 | Direction per byte: 1 = store the command byte, 0 = filler byte and return data |
| byte_rdy | output | 1 | High while outbound data is waiting |
| ob_valid | input | 1 | Outbound push valid |
| ob_ready | output | 1 | Outbound queue can accept a byte |
| ob_data | input | 8 | Outbound byte |
| ib_valid | output | 1 | Inbound byte available |
| ib_ready | input | 1 | Local side takes the inbound byte |
| ib_data | output | 8 | Inbound byte |
| underflow | output | 1 | Sticky: a filler byte found the outbound queue empty |
| overflow | output | 1 | Sticky: a command byte found the inbound queue full |

## Verification
The checks assume the host behaves as a slow mode-0 master. SCLK stays low whenever chip select changes. Each SCLK half period lasts several system clocks, and the direction line is settled well before the first rising edge of a byte. The stimulus meets these conditions with a half period of eight system clocks, a chip-select lead of sixteen clocks, and the direction set a full half period ahead of each byte. MOSI changes only together with SCLK falling. The only case that breaks the host's normal contract on purpose is a filler byte sent against an empty outbound queue, and the bench does this deliberately to exercise the underflow path.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] octet_t;
  typedef enum logic {
    XFER_FETCH = 1'b0,
    XFER_STORE = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/ssb_sync.sv
module ssb_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= RST_VAL;
    else        stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= RST_VAL;
      else        stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/ssb_fifo.sv
module ssb_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             do_wr, do_rd;

  assign in_ready  = (cnt != FULL_CNT);
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rd_ptr];
  assign do_wr     = in_valid && in_ready;
  assign do_rd     = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R10: occupancy never exceeds capacity
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);
  // R10: a full queue with no pop stays full (offered byte not taken)
  p_full_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !do_rd) |=> !in_ready);
  // R10: head data is held while the consumer stalls
  p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/ssb_spi_engine.sv
module ssb_spi_engine
  import ssb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk_s,
  input  logic   mosi_s,
  input  logic   cs_n_s,
  input  logic   rd_s,
  input  octet_t tx_head,
  input  logic   tx_avail,
  output logic   tx_take,
  output octet_t rx_byte,
  output logic   rx_put,
  input  logic   rx_room,
  output logic   miso,
  output logic   underflow,
  output logic   overflow
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

  logic            sclk_q;
  logic [CW-1:0]   bit_cnt;
  xfer_dir_e       dir_q;
  logic [BYTE_W-2:0] rx_sh;
  octet_t          tx_sh;
  octet_t          preview;
  logic            rise, fall, first_bit, last_bit;

  assign rise      = !cs_n_s && sclk_s && !sclk_q;
  assign fall      = !cs_n_s && !sclk_s && sclk_q;
  assign first_bit = (bit_cnt == '0);
  assign last_bit  = (bit_cnt == LAST_BIT);
  assign preview   = tx_avail ? tx_head : '0;

  always_comb begin
    tx_take = rise && first_bit && !rd_s && tx_avail;
    rx_byte = {rx_sh, mosi_s};
    rx_put  = rise && last_bit && (dir_q == XFER_STORE) && rx_room;
    miso    = first_bit ? preview[BYTE_W-1] : tx_sh[BYTE_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      bit_cnt   <= '0;
      dir_q     <= XFER_FETCH;
      rx_sh     <= '0;
      tx_sh     <= '0;
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else begin
        if (rise) begin
          bit_cnt <= bit_cnt + 1'b1;
          rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_s};
          if (first_bit) begin
            dir_q <= rd_s ? XFER_STORE : XFER_FETCH;
            tx_sh <= preview;
            if (!rd_s && !tx_avail) underflow <= 1'b1;
          end
          if (last_bit && (dir_q == XFER_STORE) && !rx_room) overflow <= 1'b1;
        end
        if (fall && !first_bit) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  // R7: underflow flag is sticky
  p_udf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  // R8: overflow flag is sticky
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R5: direction latched for a byte does not move mid-byte
  p_dir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_s && !first_bit && !rise) |=> $stable(dir_q));
  // R3: MISO only moves on an SCLK edge inside a byte
  p_miso_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_s && !first_bit && !rise && !fall) |=> $stable(miso));
  // R9: chip select high clears framing
  p_cs_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> first_bit);
endmodule

// File: rtl/spi_sideband_bridge.sv
module spi_sideband_bridge
  import ssb_pkg::*;
#(
  parameter int OB_DEPTH    = 8,
  parameter int IB_DEPTH    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              spi_miso,
  input  logic              host_read,
  output logic              byte_rdy,
  input  logic              ob_valid,
  output logic              ob_ready,
  input  logic [BYTE_W-1:0] ob_data,
  output logic              ib_valid,
  input  logic              ib_ready,
  output logic [BYTE_W-1:0] ib_data,
  output logic              underflow,
  output logic              overflow
);
  localparam int SYNC_W = 4;

  logic [SYNC_W-1:0] pins_raw, pins_s;
  octet_t tx_head, rx_byte;
  logic   tx_avail, tx_take, rx_put, rx_room;

  assign pins_raw = {host_read, spi_cs_n, spi_mosi, spi_sclk};

  ssb_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  ssb_fifo #(.WIDTH(BYTE_W), .DEPTH(OB_DEPTH)) u_ob_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ob_valid), .in_ready(ob_ready), .in_data(ob_data),
    .out_valid(tx_avail), .out_ready(tx_take), .out_data(tx_head)
  );

  ssb_fifo #(.WIDTH(BYTE_W), .DEPTH(IB_DEPTH)) u_ib_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_put), .in_ready(rx_room), .in_data(rx_byte),
    .out_valid(ib_valid), .out_ready(ib_ready), .out_data(ib_data)
  );

  ssb_spi_engine u_engine (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[0]), .mosi_s(pins_s[1]), .cs_n_s(pins_s[2]), .rd_s(pins_s[3]),
    .tx_head(tx_head), .tx_avail(tx_avail), .tx_take(tx_take),
    .rx_byte(rx_byte), .rx_put(rx_put), .rx_room(rx_room),
    .miso(spi_miso), .underflow(underflow), .overflow(overflow)
  );

  assign byte_rdy = tx_avail;

  // R2: an accepted push raises byte-ready on the next clock
  p_rdy_after_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_valid && ob_ready) |=> byte_rdy);
  // R8: a byte is never pushed into a full inbound queue
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_put |-> rx_room);
endmodule

// File: tb/spi_sideband_bridge_tb.sv
module spi_sideband_bridge_tb;
  localparam int HALF = 8;
  localparam int LEAD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1, rd = 1'b0;
  logic miso, byte_rdy;
  logic ob_valid = 1'b0, ob_ready;
  logic [7:0] ob_data = '0;
  logic ib_valid, ib_ready = 1'b0;
  logic [7:0] ib_data;
  logic underflow, overflow;
  logic drain_en = 1'b1;
  logic [7:0] dummy;

  int n_vec = 0, n_bad = 0;
  logic [7:0] exp_rx[$];
  logic [7:0] tx_model[$];

  always #4 clk = ~clk;

  spi_sideband_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
    .spi_miso(miso), .host_read(rd), .byte_rdy(byte_rdy),
    .ob_valid(ob_valid), .ob_ready(ob_ready), .ob_data(ob_data),
    .ib_valid(ib_valid), .ib_ready(ib_ready), .ib_data(ib_data),
    .underflow(underflow), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_ob(input logic [7:0] b);
    @(negedge clk);
    ob_valid = 1'b1;
    ob_data  = b;
    while (!ob_ready) @(negedge clk);
    @(negedge clk);
    ob_valid = 1'b0;
    tx_model.push_back(b);
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    wait_clk(LEAD);
  endtask

  task automatic cs_off();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(LEAD);
  endtask

  task automatic spi_xfer(input logic dir, input logic [7:0] mo, input bit flip, output logic [7:0] mi);
    rd = dir;
    wait_clk(HALF);
    for (int i = 7; i >= 0; i--) begin
      mosi = mo[i];
      wait_clk(HALF);
      mi[i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
      if (flip && i == 7) rd = ~dir;
    end
  endtask

  task automatic write_byte(input logic [7:0] b, input bit flip, input bit kept);
    logic [7:0] mi;
    if (kept) exp_rx.push_back(b);
    spi_xfer(1'b1, b, flip, mi);
  endtask

  task automatic read_byte(input bit flip, input string tag);
    logic [7:0] mi, exp;
    exp = (tx_model.size() != 0) ? tx_model.pop_front() : 8'h00;
    spi_xfer(1'b0, 8'h5A, flip, mi);
    chk(mi == exp, tag, mi, exp);
  endtask

  task automatic wait_drained();
    while (exp_rx.size() != 0) @(negedge clk);
    wait_clk(4);
  endtask

  // monitor: pops the inbound stream and compares against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (ib_ready) begin
        ib_ready = 1'b0;
      end else if (drain_en && rst_n && ib_valid) begin
        if (exp_rx.size() == 0) begin
          chk(1'b0, "R3 unexpected inbound byte", ib_data, 8'h00);
        end else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          chk(ib_data == e, "R3 inbound byte", ib_data, e);
        end
        ib_ready = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    // R1 reset state
    chk(byte_rdy == 1'b0, "R1 byte_rdy", {7'd0, byte_rdy}, 8'h00);
    chk(ib_valid == 1'b0, "R1 ib_valid", {7'd0, ib_valid}, 8'h00);
    chk(underflow == 1'b0 && overflow == 1'b0, "R1 flags", {6'd0, underflow, overflow}, 8'h00);
    chk(ob_ready == 1'b1, "R1 ob_ready", {7'd0, ob_ready}, 8'h01);
    chk(miso == 1'b0, "R1 miso", {7'd0, miso}, 8'h00);

    // R2 byte-ready after push
    push_ob(8'hA5);
    wait_clk(2);
    chk(byte_rdy == 1'b1, "R2 byte_rdy after push", {7'd0, byte_rdy}, 8'h01);

    // R3 single command byte
    cs_on();
    write_byte(8'h3C, 1'b0, 1'b1);
    // R4 fetch byte pops outbound head
    read_byte(1'b0, "R4 miso data");
    cs_off();
    wait_drained();
    chk(byte_rdy == 1'b0, "R2 byte_rdy after pop", {7'd0, byte_rdy}, 8'h00);
    chk(underflow == 1'b0, "R4 no underflow", {7'd0, underflow}, 8'h00);

    // R6 burst of 40 bytes mixing directions
    push_ob(8'h11); push_ob(8'h22); push_ob(8'h33); push_ob(8'h44);
    cs_on();
    for (int i = 0; i < 40; i++) begin
      if (i % 10 == 5) read_byte(1'b0, "R6 burst fetch");
      else write_byte(8'(i * 7 + 3), 1'b0, 1'b1);
    end
    cs_off();
    wait_drained();
    chk(exp_rx.size() == 0, "R6 burst all delivered", 8'(exp_rx.size()), 8'h00);
    chk(byte_rdy == 1'b0, "R6 outbound emptied", {7'd0, byte_rdy}, 8'h00);

    // R5 direction sampled only at the first edge
    push_ob(8'h96);
    cs_on();
    read_byte(1'b1, "R5 fetch with late direction change");
    write_byte(8'hC3, 1'b1, 1'b1);
    cs_off();
    wait_drained();
    chk(underflow == 1'b0, "R5 no underflow", {7'd0, underflow}, 8'h00);

    // R7 fetch from empty outbound queue
    cs_on();
    read_byte(1'b0, "R7 zero on empty");
    cs_off();
    chk(underflow == 1'b1, "R7 underflow set", {7'd0, underflow}, 8'h01);
    wait_clk(40);
    chk(underflow == 1'b1, "R7 underflow sticky", {7'd0, underflow}, 8'h01);

    // R9 partial byte dropped on chip-select release
    cs_n = 1'b0;
    wait_clk(LEAD);
    rd = 1'b1;
    wait_clk(HALF);
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1;
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    cs_off();
    cs_on();
    write_byte(8'hE7, 1'b0, 1'b1);
    cs_off();
    wait_drained();
    chk(ib_valid == 1'b0, "R9 only realigned byte delivered", {7'd0, ib_valid}, 8'h00);

    // R8 inbound overflow
    drain_en = 1'b0;
    wait_clk(4);
    cs_on();
    for (int i = 0; i < 9; i++) write_byte(8'h40 + 8'(i), 1'b0, i < 8);
    cs_off();
    chk(overflow == 1'b1, "R8 overflow set", {7'd0, overflow}, 8'h01);
    chk(ib_valid == 1'b1 && ib_data == 8'h40, "R8 head intact", ib_data, 8'h40);
    drain_en = 1'b1;
    wait_drained();
    chk(overflow == 1'b1, "R8 overflow sticky", {7'd0, overflow}, 8'h01);

    // R10 outbound back-pressure
    for (int i = 0; i < 8; i++) push_ob(8'h10 + 8'(i));
    wait_clk(1);
    chk(ob_ready == 1'b0, "R10 ob_ready low when full", {7'd0, ob_ready}, 8'h00);
    @(negedge clk);
    ob_valid = 1'b1;
    ob_data  = 8'hEE;
    wait_clk(5);
    ob_valid = 1'b0;
    cs_on();
    for (int i = 0; i < 8; i++) read_byte(1'b0, "R10 ordered outbound");
    cs_off();
    chk(byte_rdy == 1'b0, "R10 offered byte not taken", {7'd0, byte_rdy}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule